// File: doc/BRIEF.md
# Safety Operating-Mode Supervisor

This block sequences a single-channel safety unit through its operating modes and classifies detected errors as transient or permanent. After power-on reset the unit waits in a startup mode while external self-tests look for permanent hardware faults. A passing result releases the unit into normal operation. A failing result sends it straight to the safe state. From normal operation the unit may enter a configuration mode on request and return from it when configuration completes.

A runtime error report does not switch the unit off at once. The supervisor moves to a suspect mode, records the error code and asks for a restart. Once the restart completes, the unit resumes normal operation under a watch window. If the same error code is reported again inside that window, the fault is judged permanent and the unit enters the safe state. If the window elapses with no error, the history is cleared and the earlier error counts as transient. The window length is an input, counted in clock cycles.

The operation-permit output is high only while the unit may drive its outputs. A stuck-low line, or a reset, therefore always means switch-off. The safe state can be left only by power-on reset.

Top module: `smsup_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mode` is 0 (startup), `restart_req` is 0 and `op_permit` is 0.
- R2: In startup, `post_done` with `post_pass` high moves `mode` to 1 (normal) at the next clock edge. `err_valid`, `cfg_req`, `cfg_done` and `rst_done` are ignored in startup.
- R3: In startup, `post_done` with `post_pass` low moves `mode` to 4 (safe) at the next clock edge, with no retry.
- R4: With no watch window open, `err_valid` in normal (1) or configuration (2) moves `mode` to 3 (suspect) at the next edge and records `err_code`.
- R5: In suspect, `restart_req` is 1. The unit stays in suspect, ignoring `err_valid`, until `rst_done` moves it to normal and opens a watch window. `restart_req` is 0 in every other mode.
- R6: During a watch window, `err_valid` in normal or configuration with `err_code` equal to the recorded code moves `mode` to 4 (safe) at the next edge.
- R7: During a watch window, `err_valid` with a different `err_code` moves `mode` to suspect and records the new code, giving it its own single retry.
- R8: The watch window covers the first `quiet_limit` error-free cycles spent in normal or configuration after the restart; a `quiet_limit` of 0 acts as 1. An error in cycle `quiet_limit` still hits the window, and an error in cycle `quiet_limit`+1 is handled as in R4.
- R9: Configuration (2) is entered only from normal on `cfg_req` and left to normal on `cfg_done`. In normal, `err_valid` takes priority over `cfg_req`. `cfg_done` is ignored in normal.
- R10: Safe (4) is absorbing. No input changes `mode`, `restart_req` or `op_permit` until `rst_n` is asserted.
- R11: `op_permit` is 1 exactly when `mode` is normal (1) or configuration (2), and 0 in startup, suspect and safe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| post_done | input | 1 | Startup self-test finished |
| post_pass | input | 1 | Startup self-test result, 1 = no fault |
| cfg_req | input | 1 | Request to enter configuration |
| cfg_done | input | 1 | Configuration finished |
| err_valid | input | 1 | A runtime checker reports an error |
| err_code | input | ERR_W | Identity of the reported error |
| rst_done | input | 1 | Requested restart has completed |
| quiet_limit | input | CNT_W | Error-free cycles needed to clear suspect history |
| mode | output | 3 | Current mode: 0 startup, 1 normal, 2 configuration, 3 suspect, 4 safe |
| restart_req | output | 1 | Restart request, high in suspect |
| op_permit | output | 1 | Operation permit; low commands the safe/switch-off condition |

## Verification
The bench places errors on both sides of the watch-window boundary: in cycle `quiet_limit` and in cycle `quiet_limit`+1 after a restart. An off-by-one counter would either switch a transient fault off or let a permanent one retry forever. It also sends a different error code inside the window and confirms a second restart. A design that compared only the presence of an error would shut down at that point. Further cases are an error and a configuration request in the same cycle, errors sent during the restart, and traffic on every input after the safe state is reached. These show whether the wrong event wins a priority, whether an in-progress retry is restarted, and whether the safe state can be left without reset.

// File: rtl/smsup_pkg.sv
package smsup_pkg;

    typedef enum logic [2:0] {
        MD_STARTUP = 3'd0,
        MD_NORMAL  = 3'd1,
        MD_CONFIG  = 3'd2,
        MD_SUSPECT = 3'd3,
        MD_SAFE    = 3'd4
    } mode_t;

    function automatic logic mode_runs(input mode_t m);
        return (m == MD_NORMAL) || (m == MD_CONFIG);
    endfunction

endpackage

// File: rtl/smsup_quiet_timer.sv
module smsup_quiet_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t            s_d, s_q;
    logic [CNT_W:0]  cnt_inc;

    always_comb begin
        s_d     = s_q;
        cnt_inc = {1'b0, s_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        expire  = tick && (cnt_inc >= {1'b0, limit});
        if (clr) begin
            s_d.cnt = '0;
        end else if (tick && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0)) else $error("timer not cleared");  // R8
    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(s_q.cnt)) else $error("timer moved idle");  // R8

endmodule

// File: rtl/smsup_mode_fsm.sv
module smsup_mode_fsm
    import smsup_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_done,
    input  logic             post_pass,
    input  logic             cfg_req,
    input  logic             cfg_done,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_code,
    input  logic             rst_done,
    input  logic             win_expire,
    output logic             win_clr,
    output logic             win_tick,
    output logic [2:0]       mode,
    output logic             restart_req,
    output logic             op_permit
);

    typedef struct packed {
        mode_t            mode;
        logic [ERR_W-1:0] held_code;
        logic             watching;
        logic             restart;
        logic             permit;
    } fsm_t;

    fsm_t s_d, s_q;
    logic same_err;

    always_comb begin
        s_d      = s_q;
        same_err = s_q.watching && (err_code == s_q.held_code);
        win_clr  = (s_q.mode == MD_SUSPECT);
        win_tick = s_q.watching && mode_runs(s_q.mode) && !err_valid;

        unique case (s_q.mode)
            MD_STARTUP: begin
                if (post_done) begin
                    s_d.mode = post_pass ? MD_NORMAL : MD_SAFE;
                end
            end
            MD_NORMAL, MD_CONFIG: begin
                if (err_valid) begin
                    if (same_err) begin
                        s_d.mode = MD_SAFE;
                    end else begin
                        s_d.mode      = MD_SUSPECT;
                        s_d.held_code = err_code;
                    end
                    s_d.watching = 1'b0;
                end else begin
                    if (win_expire) begin
                        s_d.watching = 1'b0;
                    end
                    if ((s_q.mode == MD_NORMAL) && cfg_req) begin
                        s_d.mode = MD_CONFIG;
                    end else if ((s_q.mode == MD_CONFIG) && cfg_done) begin
                        s_d.mode = MD_NORMAL;
                    end
                end
            end
            MD_SUSPECT: begin
                if (rst_done) begin
                    s_d.mode     = MD_NORMAL;
                    s_d.watching = 1'b1;
                end
            end
            default: begin
                s_d.mode = MD_SAFE;
            end
        endcase

        s_d.restart = (s_d.mode == MD_SUSPECT);
        s_d.permit  = mode_runs(s_d.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MD_STARTUP, held_code: '0, watching: 1'b0,
                     restart: 1'b0, permit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode        = s_q.mode;
    assign restart_req = s_q.restart;
    assign op_permit   = s_q.permit;

    AST_STARTUP_FAIL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_STARTUP && post_done && !post_pass) |=> (s_q.mode == MD_SAFE))
        else $error("failed self-test not safe");  // R3
    AST_NORMAL_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_STARTUP && !(post_done && post_pass)) |=> (s_q.mode != MD_NORMAL))
        else $error("normal without pass");  // R2
    AST_SUSPECT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_SUSPECT && !rst_done) |=> (s_q.mode == MD_SUSPECT))
        else $error("suspect left early");  // R5
    AST_RESTART_IN_SUSPECT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.restart |-> (s_q.mode == MD_SUSPECT)) else $error("stray restart");  // R5
    AST_REPEAT_IS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_runs(s_q.mode) && s_q.watching && err_valid && err_code == s_q.held_code)
        |=> (s_q.mode == MD_SAFE)) else $error("repeat error not safe");  // R6
    AST_CONFIG_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode != MD_NORMAL && s_q.mode != MD_CONFIG) |=> (s_q.mode != MD_CONFIG))
        else $error("config entered from wrong mode");  // R9
    AST_SAFE_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_SAFE) |=> (s_q.mode == MD_SAFE && !s_q.permit && !s_q.restart))
        else $error("safe left");  // R10
    AST_PERMIT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.permit |-> mode_runs(s_q.mode)) else $error("permit in wrong mode");  // R11

endmodule

// File: rtl/smsup_top.sv
module smsup_top #(
    parameter int ERR_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_done,
    input  logic             post_pass,
    input  logic             cfg_req,
    input  logic             cfg_done,
    input  logic             err_valid,
    input  logic [ERR_W-1:0] err_code,
    input  logic             rst_done,
    input  logic [CNT_W-1:0] quiet_limit,
    output logic [2:0]       mode,
    output logic             restart_req,
    output logic             op_permit
);

    logic win_clr, win_tick, win_expire;

    smsup_mode_fsm #(.ERR_W(ERR_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_done   (post_done),
        .post_pass   (post_pass),
        .cfg_req     (cfg_req),
        .cfg_done    (cfg_done),
        .err_valid   (err_valid),
        .err_code    (err_code),
        .rst_done    (rst_done),
        .win_expire  (win_expire),
        .win_clr     (win_clr),
        .win_tick    (win_tick),
        .mode        (mode),
        .restart_req (restart_req),
        .op_permit   (op_permit)
    );

    smsup_quiet_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .tick   (win_tick),
        .limit  (quiet_limit),
        .expire (win_expire)
    );

endmodule

// File: tb/smsup_top_tb_top.sv
`timescale 1ns/1ps
module smsup_top_tb_top;

    localparam int ERR_W = 4;
    localparam int CNT_W = 16;
    localparam logic [2:0] M_START = 3'd0, M_NORM = 3'd1, M_CFG = 3'd2,
                           M_SUSP = 3'd3, M_SAFE = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic post_done = 0, post_pass = 0, cfg_req = 0, cfg_done = 0;
    logic err_valid = 0, rst_done = 0;
    logic [ERR_W-1:0] err_code = '0;
    logic [CNT_W-1:0] quiet_limit = 16'd4;
    logic [2:0] mode;
    logic restart_req, op_permit;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    smsup_top #(.ERR_W(ERR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .post_done(post_done), .post_pass(post_pass),
        .cfg_req(cfg_req), .cfg_done(cfg_done), .err_valid(err_valid),
        .err_code(err_code), .rst_done(rst_done), .quiet_limit(quiet_limit),
        .mode(mode), .restart_req(restart_req), .op_permit(op_permit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [2:0] m);
        chk(req, "mode", int'(mode), int'(m));
        chk(req, "op_permit", int'(op_permit), (m == M_NORM || m == M_CFG) ? 1 : 0);
        chk(req, "restart_req", int'(restart_req), (m == M_SUSP) ? 1 : 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_inputs();
        post_done = 0; post_pass = 0; cfg_req = 0; cfg_done = 0;
        err_valid = 0; rst_done = 0; err_code = '0;
    endtask

    task automatic do_reset();
        clear_inputs();
        @(negedge clk);
        rst_n = 0;
        idle(2);
        chk_state("R1", M_START);
        rst_n = 1;
        @(negedge clk);
        chk_state("R1", M_START);
    endtask

    task automatic boot_ok();
        post_done = 1; post_pass = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R2", M_NORM);
    endtask

    task automatic raise_err(input logic [ERR_W-1:0] code);
        err_valid = 1; err_code = code;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic finish_restart();
        rst_done = 1;
        @(negedge clk);
        clear_inputs();
    endtask

    // R1 R2 R3 R10
    task automatic t_startup();
        do_reset();
        err_valid = 1; err_code = 4'd2; cfg_req = 1; cfg_done = 1; rst_done = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R2 ignores inputs in startup", M_START);
        post_done = 1; post_pass = 0;
        @(negedge clk);
        clear_inputs();
        chk_state("R3", M_SAFE);
        post_done = 1; post_pass = 1; cfg_req = 1; err_valid = 1; rst_done = 1;
        idle(5);
        clear_inputs();
        chk_state("R10", M_SAFE);
        do_reset();
        boot_ok();
    endtask

    // R4 R5 R8 transient path
    task automatic t_transient();
        do_reset();
        boot_ok();
        raise_err(4'd5);
        chk_state("R4", M_SUSP);
        err_valid = 1; err_code = 4'd5;
        idle(3);
        clear_inputs();
        chk_state("R5 suspect ignores errors", M_SUSP);
        finish_restart();
        chk_state("R5", M_NORM);
        idle(int'(quiet_limit));
        raise_err(4'd5);
        chk_state("R8 error after window", M_SUSP);
    endtask

    // R6 R8 boundary: error in last window cycle
    task automatic t_window_edge();
        do_reset();
        boot_ok();
        raise_err(4'd9);
        finish_restart();
        idle(int'(quiet_limit) - 1);
        raise_err(4'd9);
        chk_state("R8 error in last window cycle", M_SAFE);
    endtask

    // R6 immediate repeat
    task automatic t_recur();
        do_reset();
        boot_ok();
        raise_err(4'd3);
        finish_restart();
        raise_err(4'd3);
        chk_state("R6", M_SAFE);
    endtask

    // R7 different code gets its own retry
    task automatic t_diff();
        do_reset();
        boot_ok();
        raise_err(4'd3);
        finish_restart();
        raise_err(4'd6);
        chk_state("R7", M_SUSP);
        finish_restart();
        raise_err(4'd3);
        chk_state("R7 old code now differs", M_SUSP);
        finish_restart();
        raise_err(4'd3);
        chk_state("R6 after R7", M_SAFE);
    endtask

    // R9 configuration path
    task automatic t_config();
        do_reset();
        boot_ok();
        cfg_done = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9 cfg_done ignored in normal", M_NORM);
        cfg_req = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9", M_CFG);
        cfg_req = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9 stays in config", M_CFG);
        cfg_done = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9 back to normal", M_NORM);
        cfg_req = 1; err_valid = 1; err_code = 4'd7;
        @(negedge clk);
        clear_inputs();
        chk_state("R9 error beats cfg_req", M_SUSP);
        cfg_req = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9 no config from suspect", M_SUSP);
        finish_restart();
        cfg_req = 1;
        @(negedge clk);
        clear_inputs();
        chk_state("R9", M_CFG);
        raise_err(4'd7);
        chk_state("R6 repeat in config", M_SAFE);
    endtask

    // R8 limit of zero acts as one
    task automatic t_zero_limit();
        quiet_limit = '0;
        do_reset();
        boot_ok();
        raise_err(4'd1);
        finish_restart();
        raise_err(4'd1);
        chk_state("R8 zero limit first cycle", M_SAFE);
        do_reset();
        boot_ok();
        raise_err(4'd1);
        finish_restart();
        idle(1);
        raise_err(4'd1);
        chk_state("R8 zero limit second cycle", M_SUSP);
        quiet_limit = 16'd4;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            summary();
        end
    end

    initial begin
        t_startup();
        t_transient();
        t_window_edge();
        t_recur();
        t_diff();
        t_config();
        t_zero_limit();
        quiet_limit = 16'd12;
        t_window_edge();
        summary();
    end

endmodule